// File: doc/BRIEF.md
# Floating-Point Status and Counter CSR Unit

This unit is the control-status register file of a small 32/64-bit integer core. Each access names a 12-bit CSR address, an operation and a source operand. The operation is a plain write, a bit set or a bit clear, and the unit returns the value the register held before the access. A separate mode input selects 32-bit or 64-bit register width, and a retire strobe advances the event counters.

One 8-bit physical floating-point status register sits behind three addresses. The rounding-mode view and the exception-flag view are bit fields of that register, so a write through any of the three addresses is seen by the other two on the very next access. The unit also holds a cycle counter and a retired-instruction counter, a time view, an ISA identification word and an implementation identifier. In 32-bit mode the upper halves of the counters are reached through separate high addresses. Unknown addresses, and high-half addresses used in 64-bit mode, are flagged as illegal.

Top module: `csr_file_unit`

## Requirements
- R1: A request sampled with req_valid high produces rsp_valid high exactly one clock later. rsp_data carries the register value from before the access, and no request means no response.
- R2: req_op encodes 00 as read only (no write), 01 as write operand, 10 as old OR operand and 11 as old AND NOT operand. Set and clear work on the view addressed.
- R3: Address 0x003 is the full floating-point status register. It holds 8 bits, a write keeps the low 8 bits of the result, and bits above 7 read as zero.
- R4: Address 0x002 is the rounding-mode view, 3 bits mapped to status bits 7:5. A write changes only those bits and keeps the low 3 bits of the result.
- R5: Address 0x001 is the exception-flag view, 5 bits mapped to status bits 4:0. A write changes only those bits and keeps the low 5 bits of the result.
- R6: The cycle counter (0xC00) and retired-instruction counter (0xC02) reset to zero. Each grows by one on every clock with retire high. The time address 0xC01 reads the cycle count.
- R7: In 32-bit mode (mode_rv32=1) the low addresses return counter bits 31:0, and 0xC80, 0xC81 and 0xC82 return bits 63:32. In 64-bit mode the low addresses return all 64 bits, and any access to the three high addresses is illegal.
- R8: Address 0x301 reads the ISA word, with extension letters as bit positions (default A, F, I, M: 0x1121). In 64-bit mode bits 63:62 are 2. In 32-bit mode bits 31:30 are 1 and the upper word is zero.
- R9: Address 0xF13 reads the implementation identifier 0x8000.
- R10: An access to any other address sets rsp_illegal, returns zero and changes no state.
- R11: Writes, sets and clears aimed at the counters, the ISA word or the identifier leave them unchanged and are not illegal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_addr | input | 12 | CSR address |
| req_op | input | 2 | Operation: 00 read, 01 write, 10 set, 11 clear |
| req_operand | input | XLEN | Source operand |
| mode_rv32 | input | 1 | 1 selects 32-bit register width |
| retire | input | 1 | One instruction retired this cycle |
| rsp_valid | output | 1 | Response present |
| rsp_data | output | XLEN | Register value before the access |
| rsp_illegal | output | 1 | Access was illegal |

## Verification
The checker assumes that every input is known after reset and that mode_rv32 and the request fields are valid only in the cycle where req_valid is high. It also assumes the counters cannot reach a 64-bit wrap within a run. The stimulus changes every input on the falling edge and presents each request for one cycle with a fixed mode. Retire pulses are issued only between accesses, so every counter read has a single expected value. Because the 32-bit wrap into the high half is out of reach in a short run, the stimulus checks the high-half view at zero and the low view at a small count.

// File: rtl/csr_unit_pkg.sv
package csr_unit_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'b00,
        OP_WRITE = 2'b01,
        OP_SET   = 2'b10,
        OP_CLEAR = 2'b11
    } csr_op_e;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_FLAGS,
        SEL_RMODE,
        SEL_FSTAT,
        SEL_CYC,
        SEL_TIME,
        SEL_RET,
        SEL_CYC_HI,
        SEL_TIME_HI,
        SEL_RET_HI,
        SEL_ISA,
        SEL_IMPL
    } csr_sel_e;

    localparam int CSR_ADDR_W = 12;

    localparam logic [CSR_ADDR_W-1:0] A_FLAGS   = 12'h001;
    localparam logic [CSR_ADDR_W-1:0] A_RMODE   = 12'h002;
    localparam logic [CSR_ADDR_W-1:0] A_FSTAT   = 12'h003;
    localparam logic [CSR_ADDR_W-1:0] A_ISA     = 12'h301;
    localparam logic [CSR_ADDR_W-1:0] A_CYC     = 12'hC00;
    localparam logic [CSR_ADDR_W-1:0] A_TIME    = 12'hC01;
    localparam logic [CSR_ADDR_W-1:0] A_RET     = 12'hC02;
    localparam logic [CSR_ADDR_W-1:0] A_CYC_HI  = 12'hC80;
    localparam logic [CSR_ADDR_W-1:0] A_TIME_HI = 12'hC81;
    localparam logic [CSR_ADDR_W-1:0] A_RET_HI  = 12'hC82;
    localparam logic [CSR_ADDR_W-1:0] A_IMPL    = 12'hF13;

    localparam int FLAG_W   = 5;
    localparam int RMODE_W  = 3;
    localparam int FSTAT_W  = FLAG_W + RMODE_W;
    localparam int RMODE_LO = FLAG_W;

    localparam int HALF_W   = 32;
    localparam int N_COUNT  = 2;
    localparam int IDX_CYC  = 0;
    localparam int IDX_RET  = 1;

endpackage

// File: rtl/csr_addr_decode.sv
module csr_addr_decode
    import csr_unit_pkg::*;
(
    input  logic [CSR_ADDR_W-1:0] addr,
    input  logic                  mode_rv32,
    output csr_sel_e              sel,
    output logic                  illegal
);

    logic hi_half;

    always_comb begin
        sel     = SEL_NONE;
        hi_half = 1'b0;
        case (addr)
            A_FLAGS:   sel = SEL_FLAGS;
            A_RMODE:   sel = SEL_RMODE;
            A_FSTAT:   sel = SEL_FSTAT;
            A_ISA:     sel = SEL_ISA;
            A_CYC:     sel = SEL_CYC;
            A_TIME:    sel = SEL_TIME;
            A_RET:     sel = SEL_RET;
            A_CYC_HI:  begin sel = SEL_CYC_HI;  hi_half = 1'b1; end
            A_TIME_HI: begin sel = SEL_TIME_HI; hi_half = 1'b1; end
            A_RET_HI:  begin sel = SEL_RET_HI;  hi_half = 1'b1; end
            A_IMPL:    sel = SEL_IMPL;
            default:   sel = SEL_NONE;
        endcase
        // high counter halves only exist in 32-bit mode
        illegal = (sel == SEL_NONE) || (hi_half && !mode_rv32);
    end

endmodule

// File: rtl/csr_rmw.sv
module csr_rmw
    import csr_unit_pkg::*;
#(
    parameter int W = 8
) (
    input  csr_op_e        op,
    input  logic [W-1:0]   old_val,
    input  logic [W-1:0]   operand,
    output logic [W-1:0]   new_val,
    output logic           wr_en
);

    always_comb begin
        wr_en   = 1'b1;
        new_val = old_val;
        case (op)
            OP_WRITE: new_val = operand;
            OP_SET:   new_val = old_val | operand;
            OP_CLEAR: new_val = old_val & ~operand;
            default:  wr_en   = 1'b0;
        endcase
    end

endmodule

// File: rtl/csr_fp_status.sv
module csr_fp_status
    import csr_unit_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  csr_sel_e           sel,
    input  logic [FSTAT_W-1:0] new_val,
    output logic [FSTAT_W-1:0] fstat_q
);

    logic [FSTAT_W-1:0] fstat_d;

    always_comb begin
        fstat_d = fstat_q;
        if (wr_en) begin
            case (sel)
                SEL_FLAGS: fstat_d[FLAG_W-1:0] = new_val[FLAG_W-1:0];
                SEL_RMODE: fstat_d[FSTAT_W-1:RMODE_LO] = new_val[RMODE_W-1:0];
                SEL_FSTAT: fstat_d = new_val;
                default:   fstat_d = fstat_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fstat_q <= '0;
        else        fstat_q <= fstat_d;
    end

endmodule

// File: rtl/csr_event_counter.sv
module csr_event_counter #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count_q
);

    logic [W-1:0] count_d;

    always_comb begin
        count_d = count_q;
        if (inc) count_d = count_q + W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

endmodule

// File: rtl/csr_file_unit.sv
module csr_file_unit
    import csr_unit_pkg::*;
#(
    parameter int          XLEN    = 64,
    parameter int          CNT_W   = 64,
    parameter int          EXT_W   = 26,
    parameter logic [25:0] ISA_EXT = 26'h0001121,
    parameter logic [15:0] IMPL_ID = 16'h8000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [CSR_ADDR_W-1:0] req_addr,
    input  logic [1:0]            req_op,
    input  logic [XLEN-1:0]       req_operand,
    input  logic                  mode_rv32,
    input  logic                  retire,
    output logic                  rsp_valid,
    output logic [XLEN-1:0]       rsp_data,
    output logic                  rsp_illegal
);

    localparam int UPPER_W   = XLEN - HALF_W;
    localparam int ISA_GAP64 = XLEN - 2 - EXT_W;
    localparam int ISA_GAP32 = HALF_W - 2 - EXT_W;
    localparam int ID_PAD    = XLEN - 16;

    typedef struct packed {
        logic            valid;
        logic            illegal;
        logic [XLEN-1:0] data;
    } rsp_t;

    csr_sel_e           sel;
    logic               illegal;
    csr_op_e            op_e;
    logic [FSTAT_W-1:0] fstat_q;
    logic [FSTAT_W-1:0] rmw_new;
    logic               rmw_wr;
    logic               fp_hit;
    logic               fp_wr;
    logic [XLEN-1:0]    read_val;
    logic [CNT_W-1:0]   cnt_q [N_COUNT];
    logic [CNT_W-1:0]   cycle_cnt;
    logic [CNT_W-1:0]   instret_cnt;
    logic [XLEN-1:0]    isa_val;
    rsp_t               rsp_d;
    rsp_t               rsp_q;

    assign op_e = csr_op_e'(req_op);

    csr_addr_decode u_dec (
        .addr      (req_addr),
        .mode_rv32 (mode_rv32),
        .sel       (sel),
        .illegal   (illegal)
    );

    // both event counters advance on the same retire strobe
    for (genvar g = 0; g < N_COUNT; g++) begin : g_cnt
        csr_event_counter #(.W(CNT_W)) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .inc     (retire),
            .count_q (cnt_q[g])
        );
    end

    assign cycle_cnt   = cnt_q[IDX_CYC];
    assign instret_cnt = cnt_q[IDX_RET];

    function automatic logic [XLEN-1:0] lo_view(input logic [CNT_W-1:0] c, input logic m32);
        if (m32) return {{UPPER_W{1'b0}}, c[HALF_W-1:0]};
        return c[XLEN-1:0];
    endfunction

    function automatic logic [XLEN-1:0] hi_view(input logic [CNT_W-1:0] c);
        return {{UPPER_W{1'b0}}, c[CNT_W-1:CNT_W-HALF_W]};
    endfunction

    always_comb begin
        if (mode_rv32) isa_val = {{UPPER_W{1'b0}}, 2'b01, {ISA_GAP32{1'b0}}, ISA_EXT};
        else           isa_val = {2'b10, {ISA_GAP64{1'b0}}, ISA_EXT};
    end

    // value seen before the access
    always_comb begin
        read_val = '0;
        case (sel)
            SEL_FLAGS:   read_val = {{(XLEN-FLAG_W){1'b0}}, fstat_q[FLAG_W-1:0]};
            SEL_RMODE:   read_val = {{(XLEN-RMODE_W){1'b0}}, fstat_q[FSTAT_W-1:RMODE_LO]};
            SEL_FSTAT:   read_val = {{(XLEN-FSTAT_W){1'b0}}, fstat_q};
            SEL_CYC:     read_val = lo_view(cycle_cnt, mode_rv32);
            SEL_TIME:    read_val = lo_view(cycle_cnt, mode_rv32);
            SEL_RET:     read_val = lo_view(instret_cnt, mode_rv32);
            SEL_CYC_HI:  read_val = hi_view(cycle_cnt);
            SEL_TIME_HI: read_val = hi_view(cycle_cnt);
            SEL_RET_HI:  read_val = hi_view(instret_cnt);
            SEL_ISA:     read_val = isa_val;
            SEL_IMPL:    read_val = {{ID_PAD{1'b0}}, IMPL_ID};
            default:     read_val = '0;
        endcase
    end

    csr_rmw #(.W(FSTAT_W)) u_rmw (
        .op      (op_e),
        .old_val (read_val[FSTAT_W-1:0]),
        .operand (req_operand[FSTAT_W-1:0]),
        .new_val (rmw_new),
        .wr_en   (rmw_wr)
    );

    assign fp_hit = (sel == SEL_FLAGS) || (sel == SEL_RMODE) || (sel == SEL_FSTAT);
    assign fp_wr  = req_valid && !illegal && rmw_wr && fp_hit;

    csr_fp_status u_fp (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (fp_wr),
        .sel     (sel),
        .new_val (rmw_new),
        .fstat_q (fstat_q)
    );

    always_comb begin
        rsp_d.valid   = req_valid;
        rsp_d.illegal = req_valid && illegal;
        rsp_d.data    = (req_valid && !illegal) ? read_val : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid   = rsp_q.valid;
    assign rsp_illegal = rsp_q.illegal;
    assign rsp_data    = rsp_q.data;

endmodule

// File: rtl/csr_file_checker.sv
module csr_file_checker
    import csr_unit_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int CNT_W = 64
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  req_valid,
    input logic [CSR_ADDR_W-1:0] req_addr,
    input logic                  mode_rv32,
    input logic                  retire,
    input logic                  rsp_valid,
    input logic [XLEN-1:0]       rsp_data,
    input logic                  rsp_illegal,
    input logic [FSTAT_W-1:0]    fstat_q,
    input logic [CNT_W-1:0]      cycle_cnt,
    input logic [CNT_W-1:0]      instret_cnt
);

    logic hi_addr;
    assign hi_addr = (req_addr == A_CYC_HI) || (req_addr == A_TIME_HI) || (req_addr == A_RET_HI);

    assert_rsp_follows_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_no_rsp_without_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    assert_illegal_reads_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_illegal |-> (rsp_data == '0));

    assert_hi_half_illegal_64_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !mode_rv32 && hi_addr) |=> rsp_illegal);

    assert_cycle_steps_R6: assert property (@(posedge clk) disable iff (!rst_n)
        retire |=> (cycle_cnt == $past(cycle_cnt) + CNT_W'(1)));

    assert_cycle_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !retire |=> $stable(cycle_cnt));

    assert_counters_agree_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_cnt == instret_cnt);

    assert_fstat_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(fstat_q));

    assert_impl_id_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr == A_IMPL) |=> (rsp_data == XLEN'(16'h8000)));

endmodule

bind csr_file_unit csr_file_checker #(.XLEN(XLEN), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_addr    (req_addr),
    .mode_rv32   (mode_rv32),
    .retire      (retire),
    .rsp_valid   (rsp_valid),
    .rsp_data    (rsp_data),
    .rsp_illegal (rsp_illegal),
    .fstat_q     (fstat_q),
    .cycle_cnt   (cycle_cnt),
    .instret_cnt (instret_cnt)
);

// File: tb/csr_file_unit_test.sv
module csr_file_unit_test;

    localparam int  XLEN     = 64;
    localparam time CLK_HALF = 5ns;

    localparam logic [1:0] RD = 2'b00, WR = 2'b01, ST = 2'b10, CL = 2'b11;
    localparam logic [63:0] ISA64 = 64'h8000_0000_0000_1121;
    localparam logic [63:0] ISA32 = 64'h0000_0000_4000_1121;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic [11:0]     req_addr = '0;
    logic [1:0]      req_op = '0;
    logic [XLEN-1:0] req_operand = '0;
    logic            mode_rv32 = 1'b0;
    logic            retire = 1'b0;
    logic            rsp_valid;
    logic [XLEN-1:0] rsp_data;
    logic            rsp_illegal;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        logic [63:0] data;
        logic        ill;
        string       tag;
    } exp_t;

    exp_t sb[$];

    always #(CLK_HALF) clk = ~clk;

    csr_file_unit #(.XLEN(XLEN)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_addr    (req_addr),
        .req_op      (req_op),
        .req_operand (req_operand),
        .mode_rv32   (mode_rv32),
        .retire      (retire),
        .rsp_valid   (rsp_valid),
        .rsp_data    (rsp_data),
        .rsp_illegal (rsp_illegal)
    );

    task automatic access(input logic [11:0] a, input logic [1:0] op, input logic [63:0] opnd,
                          input bit m32, input logic [63:0] exp_d, input bit exp_i, input string tag);
        exp_t e;
        @(negedge clk);
        req_valid   = 1'b1;
        req_addr    = a;
        req_op      = op;
        req_operand = opnd;
        mode_rv32   = m32;
        e.data = exp_d;
        e.ill  = exp_i;
        e.tag  = tag;
        sb.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
        end
    endtask

    task automatic retire_n(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
            retire    = 1'b1;
        end
        @(negedge clk);
        retire = 1'b0;
    endtask

    // monitor: compares each response against the oldest expected item
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            checks++;
            if (sb.size() == 0) begin
                failures++;
                $display("FAIL R1 unexpected response: actual data=%h expected none", rsp_data);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (rsp_data !== e.data || rsp_illegal !== e.ill) begin
                    failures++;
                    $display("FAIL %s: actual data=%h ill=%0b expected data=%h ill=%0b",
                             e.tag, rsp_data, rsp_illegal, e.data, e.ill);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual running expected finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0 || rsp_data !== '0 || rsp_illegal !== 1'b0) begin
            failures++;
            $display("FAIL R1 reset state: actual v=%0b d=%h i=%0b expected 0 0 0",
                     rsp_valid, rsp_data, rsp_illegal);
        end

        // status register and its two views
        access(12'h003, RD, 64'hFF, 0, 64'h0, 0, "R2 read-only op");
        access(12'h003, RD, 64'h0, 0, 64'h0, 0, "R2 read op wrote nothing");
        access(12'h003, WR, 64'hFFFF_FFE5, 0, 64'h0, 0, "R3 write old value");
        access(12'h003, RD, 64'h0, 0, 64'hE5, 0, "R3 low 8 bits kept");
        access(12'h002, RD, 64'h0, 0, 64'h7, 0, "R4 rounding view of full write");
        access(12'h001, RD, 64'h0, 0, 64'h5, 0, "R5 flag view of full write");
        access(12'h002, WR, 64'h1A, 0, 64'h7, 0, "R4 rounding write old value");
        access(12'h003, RD, 64'h0, 0, 64'h45, 0, "R4 rounding write lands in 7:5");
        access(12'h001, ST, 64'h38, 0, 64'h5, 0, "R5 flag set old value");
        access(12'h003, RD, 64'h0, 0, 64'h5D, 0, "R5 flag set truncated to 5 bits");
        access(12'h003, CL, 64'h0F, 0, 64'h5D, 0, "R2 clear old value");
        access(12'h002, RD, 64'h0, 0, 64'h2, 0, "R2 clear leaves rounding");
        access(12'h001, RD, 64'h0, 0, 64'h10, 0, "R2 clear result in flags");
        access(12'h002, CL, 64'h7, 1, 64'h2, 0, "R4 rounding clear old value");
        access(12'h003, RD, 64'h0, 1, 64'h10, 0, "R4 rounding clear result");

        // unimplemented address
        access(12'h7C0, WR, 64'hFFFF, 0, 64'h0, 1, "R10 unknown address");
        access(12'h003, RD, 64'h0, 0, 64'h10, 0, "R10 no state change");

        // identification
        access(12'h301, WR, 64'h0, 0, ISA64, 0, "R8 ISA word 64-bit");
        access(12'h301, RD, 64'h0, 0, ISA64, 0, "R11 ISA unchanged by write");
        access(12'h301, RD, 64'h0, 1, ISA32, 0, "R8 ISA word 32-bit");
        access(12'hF13, ST, 64'hFFFF, 0, 64'h8000, 0, "R9 impl id");
        access(12'hF13, RD, 64'h0, 0, 64'h8000, 0, "R11 impl id unchanged");

        // counters
        access(12'hC00, RD, 64'h0, 0, 64'h0, 0, "R6 cycle reset zero");
        idle(2);
        retire_n(5);
        access(12'hC00, RD, 64'h0, 0, 64'd5, 0, "R6 cycle after 5 retires");
        access(12'hC02, RD, 64'h0, 0, 64'd5, 0, "R6 instret after 5 retires");
        access(12'hC01, RD, 64'h0, 0, 64'd5, 0, "R6 time mirrors cycle");
        access(12'hC00, WR, 64'h0, 0, 64'd5, 0, "R11 counter write old value");
        access(12'hC00, RD, 64'h0, 0, 64'd5, 0, "R11 counter unchanged");
        access(12'hC80, RD, 64'h0, 0, 64'h0, 1, "R7 cycle high in 64-bit mode");
        access(12'hC81, RD, 64'h0, 0, 64'h0, 1, "R7 time high in 64-bit mode");
        access(12'hC82, WR, 64'h1, 0, 64'h0, 1, "R7 instret high in 64-bit mode");
        access(12'hC80, RD, 64'h0, 1, 64'h0, 0, "R7 cycle high in 32-bit mode");
        access(12'hC82, RD, 64'h0, 1, 64'h0, 0, "R7 instret high in 32-bit mode");
        access(12'hC02, RD, 64'h0, 1, 64'd5, 0, "R7 instret low in 32-bit mode");
        idle(3);
        retire_n(2);
        access(12'hC00, RD, 64'h0, 1, 64'd7, 0, "R6 cycle keeps counting");
        idle(3);

        checks++;
        if (sb.size() != 0) begin
            failures++;
            $display("FAIL R1 missing responses: actual %0d pending expected 0", sb.size());
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule